// File: doc/BRIEF.md
# Nibble-Wide DRAM Byte Access Controller

This block lets a host that works in bytes read and write a DRAM whose data bus is only four bits wide. Every host byte occupies two memory nibbles that share one row and one column. The most significant memory address line (A8) picks the nibble: A8 low holds bits 3:0 and A8 high holds bits 7:4. One access opens the row once, runs two page-mode CAS cycles inside that single RAS period, and then closes the row.

The host presents a 16-bit address together with a read or write request. The upper address byte becomes the row address and the lower byte becomes the column address, and A8 supplies the ninth memory address bit. For a write the host also presents a byte. While the sequence runs the controller holds `busy` high. It ends by pulsing `done` for one cycle, and after a read the assembled byte is on `rd_data`. On the memory side the controller drives a 9-bit multiplexed address and four active-low strobes (RAS, CAS, OE, W). The 4-bit data bus is split into input, output and output-enable pins. Every strobe-edge spacing is `GAP` clock cycles. Each read CAS phase lasts `RD_WAIT` cycles, and the data is sampled on its last cycle.

Top module: `nib_dram_ctrl`

## Requirements
- R1: After reset, all four strobes are high, `busy`, `done` and `dq_oe` are 0, `mem_addr` is 0 and `dq_out` is 0.
- R2: When the controller is idle, a request is accepted on a clock edge. `busy` is high from the next cycle. The row address {0, addr[15:8]} is driven for GAP cycles with RAS high, then for GAP cycles with RAS low.
- R3: After RAS falls, the column address {0, addr[7:0]} (A8 = 0) is driven for GAP cycles before the first CAS fall.
- R4: On a read, CAS and OE fall together and stay low for RD_WAIT cycles. The value of `dq_in` in the last of those cycles becomes bits 3:0 of the read byte.
- R5: On a read, CAS then rises for GAP cycles while A8 goes to 1 and OE stays low. CAS then falls again for RD_WAIT cycles, and `dq_in` in the last of those cycles becomes bits 7:4.
- R6: A read ends by raising OE, then CAS, then RAS. Each of these steps lasts GAP cycles.
- R7: A write uses early write. During the column phase, before the first CAS fall, W is low, `dq_oe` is 1 and `dq_out` carries wdata[3:0].
- R8: On a write, CAS is pulsed low for GAP cycles with A8 = 0 and the low nibble. A8 then goes to 1, the high nibble wdata[7:4] is presented, and CAS is pulsed again. After that CAS goes high. Finally RAS and W go high and `dq_oe` drops, all in the same step.
- R9: `dq_oe` is never 1 while OE is low. `dq_out` is 0 whenever `dq_oe` is 0.
- R10: A request that arrives while `busy` is high is ignored. It neither changes the running sequence nor reaches the memory.
- R11: If read and write are requested in the same cycle, the read is performed and the memory is left unchanged.
- R12: `done` is a one-cycle pulse in the first idle cycle after RAS has returned high. After a read, `rd_data` holds the byte at that time.
- R13: CAS is low only while RAS is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_rd | input | 1 | Read request, sampled while idle |
| req_wr | input | 1 | Write request, sampled while idle |
| req_addr | input | 16 | Host byte address (row = high byte, column = low byte) |
| req_wdata | input | 8 | Byte to write |
| busy | output | 1 | High from acceptance until all strobes are inactive |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Byte assembled by the last read |
| mem_addr | output | 9 | Multiplexed memory address, bit 8 selects the nibble |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| dq_in | input | 4 | Data nibble from the memory |
| dq_out | output | 4 | Data nibble toward the memory |
| dq_oe | output | 1 | Drive enable for `dq_out` onto the shared data bus |

## Verification
The assertions assume that `dq_in` is driven with a known value whenever OE and CAS are both low. They also assume that `req_rd` and `req_wr` are never unknown after reset. The bench keeps to both. Its memory model returns 0 for any location that was never written, and all request inputs are driven from tasks on falling edges. Some stimulus falls outside the normal pattern on purpose: requests raised mid-sequence, read and write raised together, and requests raised in the completion cycle. In each case the host inputs stay fully defined.

// File: rtl/nib_dram_pkg.sv
package nib_dram_pkg;

    localparam int HOST_AW = 16;
    localparam int BYTE_W  = 8;
    localparam int NIB_W   = BYTE_W / 2;
    localparam int HALF_AW = HOST_AW / 2;
    localparam int MEM_AW  = HALF_AW + 1;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ROW,
        ST_RAS,
        ST_COL,
        ST_CAS0,
        ST_PRE1,
        ST_CAS1,
        ST_REL_OE,
        ST_REL_CAS,
        ST_REL_RAS
    } seq_state_e;

    typedef enum logic {
        OP_RD = 1'b0,
        OP_WR = 1'b1
    } op_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic oe_n;
        logic we_n;
    } strobes_t;

    typedef struct packed {
        logic [HOST_AW-1:0] addr;
        logic [BYTE_W-1:0]  wdata;
    } xfer_t;

    function automatic logic is_cas_phase(seq_state_e s);
        return (s == ST_CAS0) || (s == ST_CAS1);
    endfunction

    function automatic seq_state_e next_state(seq_state_e s, op_e op);
        seq_state_e n;
        case (s)
            ST_ROW:     n = ST_RAS;
            ST_RAS:     n = ST_COL;
            ST_COL:     n = ST_CAS0;
            ST_CAS0:    n = ST_PRE1;
            ST_PRE1:    n = ST_CAS1;
            ST_CAS1:    n = (op == OP_RD) ? ST_REL_OE : ST_REL_CAS;
            ST_REL_OE:  n = ST_REL_CAS;
            ST_REL_CAS: n = ST_REL_RAS;
            default:    n = ST_IDLE;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/nib_dram_seq.sv
module nib_dram_seq
    import nib_dram_pkg::*;
#(
    parameter int GAP     = 1,
    parameter int RD_WAIT = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  op_e        start_op,
    output seq_state_e state,
    output op_e        op,
    output logic       step,
    output logic       done
);

    localparam int MAXD = (GAP > RD_WAIT) ? GAP : RD_WAIT;
    localparam int CW   = $clog2(MAXD + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] last_cnt;

    always_comb begin
        if (is_cas_phase(state) && op == OP_RD)
            last_cnt = CW'(RD_WAIT - 1);
        else
            last_cnt = CW'(GAP - 1);
    end

    assign step = (state != ST_IDLE) && (cnt == last_cnt);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            op    <= OP_RD;
            cnt   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (state == ST_IDLE) begin
                cnt <= '0;
                if (start) begin
                    state <= ST_ROW;
                    op    <= start_op;
                end
            end else if (step) begin
                cnt   <= '0;
                state <= next_state(state, op);
                if (state == ST_REL_RAS)
                    done <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    a_r2_timer_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(MAXD - 1));

    a_r12_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r12_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> (state == ST_IDLE));

endmodule

// File: rtl/nib_dram_addr.sv
module nib_dram_addr
    import nib_dram_pkg::*;
(
    input  seq_state_e         state,
    input  logic [HALF_AW-1:0] row,
    input  logic [HALF_AW-1:0] col,
    output logic [MEM_AW-1:0]  mem_addr
);

    always_comb begin
        case (state)
            ST_ROW, ST_RAS:   mem_addr = {1'b0, row};
            ST_COL, ST_CAS0:  mem_addr = {1'b0, col};
            ST_PRE1, ST_CAS1, ST_REL_OE, ST_REL_CAS, ST_REL_RAS:
                              mem_addr = {1'b1, col};
            default:          mem_addr = '0;
        endcase
    end

endmodule

// File: rtl/nib_dram_dq.sv
module nib_dram_dq
    import nib_dram_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  seq_state_e        state,
    input  op_e               op,
    input  logic              step,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [NIB_W-1:0]  dq_in,
    output strobes_t          strb,
    output logic              dq_oe,
    output logic [NIB_W-1:0]  dq_out,
    output logic [BYTE_W-1:0] rd_data
);

    logic rd;
    logic row_open;
    logic wr_span;

    assign rd = (op == OP_RD);

    always_comb begin
        row_open = 1'b0;
        wr_span  = 1'b0;
        case (state)
            ST_RAS, ST_COL, ST_CAS0, ST_PRE1, ST_CAS1, ST_REL_OE, ST_REL_CAS:
                row_open = 1'b1;
            default: row_open = 1'b0;
        endcase
        case (state)
            ST_COL, ST_CAS0, ST_PRE1, ST_CAS1, ST_REL_CAS:
                wr_span = !rd;
            default: wr_span = 1'b0;
        endcase
    end

    always_comb begin
        strb.ras_n = !row_open;
        strb.cas_n = !(is_cas_phase(state) || (state == ST_REL_OE));
        strb.oe_n  = !(rd && (is_cas_phase(state) || state == ST_PRE1));
        strb.we_n  = !wr_span;
    end

    assign dq_oe = wr_span;

    always_comb begin
        if (!wr_span)
            dq_out = '0;
        else if (state == ST_COL || state == ST_CAS0)
            dq_out = wdata[NIB_W-1:0];
        else
            dq_out = wdata[BYTE_W-1:NIB_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (step && rd) begin
            if (state == ST_CAS0)
                rd_data[NIB_W-1:0] <= dq_in;
            else if (state == ST_CAS1)
                rd_data[BYTE_W-1:NIB_W] <= dq_in;
        end
    end

    a_r9_no_contention: assert property (@(posedge clk) disable iff (rst)
        !(dq_oe && !strb.oe_n));

    a_r13_cas_in_ras: assert property (@(posedge clk) disable iff (rst)
        !strb.cas_n |-> !strb.ras_n);

    a_r7_early_write: assert property (@(posedge clk) disable iff (rst)
        ($fell(strb.cas_n) && !strb.we_n) |-> $past(!strb.we_n && dq_oe));

    a_r6_ras_last: assert property (@(posedge clk) disable iff (rst)
        $rose(strb.ras_n) |-> (strb.oe_n && strb.cas_n));

endmodule

// File: rtl/nib_dram_ctrl.sv
module nib_dram_ctrl
    import nib_dram_pkg::*;
#(
    parameter int GAP     = 1,
    parameter int RD_WAIT = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_rd,
    input  logic                req_wr,
    input  logic [HOST_AW-1:0]  req_addr,
    input  logic [BYTE_W-1:0]   req_wdata,
    output logic                busy,
    output logic                done,
    output logic [BYTE_W-1:0]   rd_data,
    output logic [MEM_AW-1:0]   mem_addr,
    output logic                mem_ras_n,
    output logic                mem_cas_n,
    output logic                mem_oe_n,
    output logic                mem_we_n,
    input  logic [NIB_W-1:0]    dq_in,
    output logic [NIB_W-1:0]    dq_out,
    output logic                dq_oe
);

    seq_state_e state;
    op_e        op;
    logic       step;
    logic       accept;
    xfer_t      cap;
    strobes_t   strb;

    assign accept = (state == ST_IDLE) && (req_rd || req_wr);
    assign busy   = (state != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            cap <= '0;
        end else if (accept) begin
            cap.addr  <= req_addr;
            cap.wdata <= req_wdata;
        end
    end

    nib_dram_seq #(
        .GAP     (GAP),
        .RD_WAIT (RD_WAIT)
    ) seq_i (
        .clk      (clk),
        .rst      (rst),
        .start    (accept),
        .start_op (req_rd ? OP_RD : OP_WR),
        .state    (state),
        .op       (op),
        .step     (step),
        .done     (done)
    );

    nib_dram_addr addr_i (
        .state    (state),
        .row      (cap.addr[HOST_AW-1:HALF_AW]),
        .col      (cap.addr[HALF_AW-1:0]),
        .mem_addr (mem_addr)
    );

    nib_dram_dq dq_i (
        .clk     (clk),
        .rst     (rst),
        .state   (state),
        .op      (op),
        .step    (step),
        .wdata   (cap.wdata),
        .dq_in   (dq_in),
        .strb    (strb),
        .dq_oe   (dq_oe),
        .dq_out  (dq_out),
        .rd_data (rd_data)
    );

    assign mem_ras_n = strb.ras_n;
    assign mem_cas_n = strb.cas_n;
    assign mem_oe_n  = strb.oe_n;
    assign mem_we_n  = strb.we_n;

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (mem_ras_n && mem_cas_n && mem_oe_n && mem_we_n && !dq_oe));

    a_r10_ignore_busy: assert property (@(posedge clk) disable iff (rst)
        (busy && (req_rd || req_wr)) |=> $stable(cap));

    a_r5_addr_stable_cas: assert property (@(posedge clk) disable iff (rst)
        (!mem_cas_n && $past(!mem_cas_n)) |-> $stable(mem_addr));

    a_r12_done_after_close: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(mem_ras_n && busy));

endmodule

// File: tb/nib_dram_ctrl_tb_top.sv
module nib_dram_ctrl_tb_top;

    localparam int G = 2;
    localparam int W = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_rd = 1'b0;
    logic        req_wr = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        busy, done;
    logic [7:0]  rd_data;
    logic [8:0]  mem_addr;
    logic        mem_ras_n, mem_cas_n, mem_oe_n, mem_we_n;
    logic [3:0]  dq_in = '0;
    logic [3:0]  dq_out;
    logic        dq_oe;

    always #5 clk = ~clk;

    nib_dram_ctrl #(.GAP(G), .RD_WAIT(W)) dut_i (
        .clk(clk), .rst(rst), .req_rd(req_rd), .req_wr(req_wr),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
        .rd_data(rd_data), .mem_addr(mem_addr), .mem_ras_n(mem_ras_n),
        .mem_cas_n(mem_cas_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    typedef struct {
        logic [19:0] v;
        logic        chk_rd;
        logic [7:0]  rd_exp;
        string       tag;
    } exp_t;

    exp_t q[$];
    exp_t cur;
    logic [7:0] bmem [int];
    logic [3:0] nmem [int];
    logic [7:0] row_l = '0;

    // Vector layout: {busy, done, addr[8:0], ras_n, cas_n, oe_n, we_n, dq_oe, dq_out[3:0]}
    function automatic logic [19:0] mk(logic b, logic d, logic [8:0] a,
            logic ras, logic cas, logic oe, logic we, logic doe, logic [3:0] dq);
        return {b, d, a, ras, cas, oe, we, doe, dq};
    endfunction

    function automatic exp_t idle_exp();
        exp_t e;
        e.v = mk(0, 0, 9'h0, 1, 1, 1, 1, 0, 4'h0);
        e.chk_rd = 0; e.rd_exp = 0; e.tag = "R1";
        return e;
    endfunction

    function automatic void push(logic [19:0] v, int n, string tag);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e.v = v; e.chk_rd = 0; e.rd_exp = 0; e.tag = tag;
            q.push_back(e);
        end
    endfunction

    function automatic void enqueue(logic is_rd, logic [15:0] a, logic [7:0] wd);
        logic [8:0] hi, lo, lo1;
        exp_t e;
        hi = {1'b0, a[15:8]}; lo = {1'b0, a[7:0]}; lo1 = {1'b1, a[7:0]};
        push(mk(1, 0, hi, 1, 1, 1, 1, 0, 0), G, "R2");
        push(mk(1, 0, hi, 0, 1, 1, 1, 0, 0), G, "R2");
        if (is_rd) begin
            push(mk(1, 0, lo,  0, 1, 1, 1, 0, 0), G, "R3");
            push(mk(1, 0, lo,  0, 0, 0, 1, 0, 0), W, "R4");
            push(mk(1, 0, lo1, 0, 1, 0, 1, 0, 0), G, "R5");
            push(mk(1, 0, lo1, 0, 0, 0, 1, 0, 0), W, "R5");
            push(mk(1, 0, lo1, 0, 0, 1, 1, 0, 0), G, "R6");
            push(mk(1, 0, lo1, 0, 1, 1, 1, 0, 0), G, "R6");
            push(mk(1, 0, lo1, 1, 1, 1, 1, 0, 0), G, "R6");
        end else begin
            push(mk(1, 0, lo,  0, 1, 1, 0, 1, wd[3:0]), G, "R7");
            push(mk(1, 0, lo,  0, 0, 1, 0, 1, wd[3:0]), G, "R8");
            push(mk(1, 0, lo1, 0, 1, 1, 0, 1, wd[7:4]), G, "R8");
            push(mk(1, 0, lo1, 0, 0, 1, 0, 1, wd[7:4]), G, "R8");
            push(mk(1, 0, lo1, 0, 1, 1, 0, 1, wd[7:4]), G, "R8");
            push(mk(1, 0, lo1, 1, 1, 1, 1, 0, 4'h0), G, "R8");
        end
        e.v = mk(0, 1, 9'h0, 1, 1, 1, 1, 0, 4'h0);
        e.chk_rd = is_rd;
        e.rd_exp = bmem.exists(int'(a)) ? bmem[int'(a)] : 8'h00;
        e.tag = "R12";
        q.push_back(e);
        if (!is_rd) bmem[int'(a)] = wd;
    endfunction

    // Reference model, advanced on each rising edge
    always @(posedge clk) begin
        if (rst) begin
            q.delete();
            cur = idle_exp();
        end else begin
            if (cur.v[19] == 1'b0 && (req_rd || req_wr))
                enqueue(req_rd, req_addr, req_wdata);
            if (q.size() > 0) cur = q.pop_front();
            else              cur = idle_exp();
        end
    end

    // Behavioural memory with a 4-bit data bus
    always @(negedge mem_ras_n) row_l = mem_addr[7:0];
    always @(negedge mem_cas_n) begin
        if (mem_we_n === 1'b0) nmem[int'({row_l, mem_addr})] = dq_out;
    end
    always @(negedge clk) begin
        int k;
        k = int'({row_l, mem_addr});
        if (!mem_ras_n && !mem_cas_n && !mem_oe_n && nmem.exists(k))
            dq_in <= nmem[k];
        else
            dq_in <= 4'h0;
    end

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (!rst && !finished) begin
            logic [19:0] act;
            act = {busy, done, mem_addr, mem_ras_n, mem_cas_n, mem_oe_n, mem_we_n, dq_oe, dq_out};
            n_chk++;
            if (act !== cur.v) begin
                n_fail++;
                $display("FAIL %s outputs actual=%h expected=%h at %0t", cur.tag, act, cur.v, $time);
            end
            n_chk++;
            if (dq_oe && !mem_oe_n) begin
                n_fail++;
                $display("FAIL R9 bus contention actual dq_oe=1 oe_n=0 expected not both");
            end
            n_chk++;
            if (!mem_cas_n && mem_ras_n) begin
                n_fail++;
                $display("FAIL R13 cas low outside ras actual ras_n=1 expected 0");
            end
            if (cur.chk_rd) begin
                n_chk++;
                if (rd_data !== cur.rd_exp) begin
                    n_fail++;
                    $display("FAIL R12 rd_data actual=%h expected=%h", rd_data, cur.rd_exp);
                end
            end
        end
    end

    task automatic check_eq(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(logic rd, logic wr, logic [15:0] a, logic [7:0] wd);
        @(negedge clk);
        req_rd = rd; req_wr = wr; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_rd = 0; req_wr = 0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic xfer(logic rd, logic wr, logic [15:0] a, logic [7:0] wd);
        issue(rd, wr, a, wd);
        wait_idle();
    endtask

    function automatic logic [3:0] nib(logic [7:0] r, logic [8:0] a);
        int k;
        k = int'({r, a});
        return nmem.exists(k) ? nmem[k] : 4'h0;
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        cur = idle_exp();
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check_eq("R1", {busy, done, mem_ras_n, mem_cas_n, mem_oe_n, mem_we_n, dq_oe},
                 {2'b00, 4'b1111, 1'b0});

        // R7 / R8 nibble placement in memory
        xfer(0, 1, 16'h1234, 8'hA5);
        check_eq("R7 low nibble at A8=0", nib(8'h12, 9'h034), 4'h5);
        check_eq("R8 high nibble at A8=1", nib(8'h12, 9'h134), 4'hA);
        xfer(0, 1, 16'h12FF, 8'h3C);
        xfer(0, 1, 16'hFF00, 8'h0F);
        xfer(0, 1, 16'h0080, 8'hF0);

        // R4 / R5 read assembly
        xfer(1, 0, 16'h1234, 8'h00);
        check_eq("R4 R5 read 1234", rd_data, 8'hA5);
        xfer(1, 0, 16'h12FF, 8'h00);
        check_eq("R4 R5 read 12FF", rd_data, 8'h3C);
        xfer(1, 0, 16'hFF00, 8'h00);
        check_eq("R4 R5 read FF00", rd_data, 8'h0F);
        xfer(1, 0, 16'h0080, 8'h00);
        check_eq("R4 R5 read 0080", rd_data, 8'hF0);
        xfer(1, 0, 16'h0001, 8'h00);
        check_eq("R4 unwritten location", rd_data, 8'h00);

        // R10 requests while busy are ignored
        issue(0, 1, 16'h4242, 8'h66);
        repeat (4) @(negedge clk);
        req_wr = 1; req_addr = 16'h4242; req_wdata = 8'h99;
        @(negedge clk);
        req_wr = 0; req_rd = 1; req_addr = 16'h1234;
        @(negedge clk);
        req_rd = 0;
        wait_idle();
        xfer(1, 0, 16'h4242, 8'h00);
        check_eq("R10 ignored write", rd_data, 8'h66);

        // R11 read wins over simultaneous write
        xfer(1, 1, 16'h12FF, 8'h77);
        check_eq("R11 read returned", rd_data, 8'h3C);
        xfer(1, 0, 16'h12FF, 8'h00);
        check_eq("R11 memory unchanged", rd_data, 8'h3C);

        // R12 request in the completion cycle, back to back
        issue(0, 1, 16'hABCD, 8'h5A);
        wait_idle();
        req_rd = 1; req_addr = 16'hABCD;
        @(negedge clk);
        req_rd = 0;
        wait_idle();
        check_eq("R12 back-to-back read", rd_data, 8'h5A);

        repeat (5) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

endmodule